// File: doc/BRIEF.md
# TDM Stream Sampler with Selectable Phase

This block moves serial time-division-multiplexed voice data on and off a bank of parallel bit-serial lines. All lines share one frame sync and one bit clock. The block runs from a clock at four times the bit rate, so each bit cell lasts four clock cycles, numbered as quarters 0 to 3. A frame holds 128 slots of eight bits, and the frame sync pulse marks quarter 0 of bit 0 of slot 0.

On receive, each line is sampled once per bit cell, in a quarter chosen by a configuration field. Eight samples are packed into one byte per line, most significant bit first. A one-cycle valid pulse then presents all bytes together with the 7-bit slot number.

On transmit, each slot's bytes and per-line enable bits are captured at the start of the slot and shifted out most significant bit first. The line's output enable follows the enable bit. At the end of the slot the enable is released either one quarter early or on the bit-clock edge, as configured. The external three-state buffers are driven from the enable and data outputs.

Top module: `tdm_phase_sampler`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rx_valid`, every bit of `tx_oe` and every bit of `tx_dout` are 0 after that edge.
- R2: A cycle with `fsync` high is quarter 0 of bit 0 of slot 0. Each later cycle advances one quarter. Bits advance after quarter 3, and slots advance after bit 7.
- R3: `smp_sel` picks the sampling quarter: 0 takes quarter 1 (the 2/4 point), 1 takes quarter 2 (3/4), and 2 or 3 take quarter 3 (4/4).
- R4: Bits are packed most significant bit first. The byte of line i appears on `rx_bytes[8i+7:8i]`.
- R5: `rx_valid` is high for exactly the one cycle that follows the sampling cycle of bit 7. In that cycle `rx_slot` carries the number of the slot just completed.
- R6: Without a frame sync, slot 127 is followed by slot 0.
- R7: A frame sync that arrives in the middle of a frame restarts the count at slot 0. The first byte after it is built from eight fresh samples.
- R8: `tx_bytes` and `tx_en` are captured in the quarter-0 cycle of bit 0 of a slot. `tx_dout` of line i changes at the edge that ends each quarter-0 cycle, carrying bit 7 of the captured byte first.
- R9: A line whose captured enable bit is 0 keeps `tx_oe` at 0 for the whole slot. A line whose bit is 1 drives `tx_oe` at 1.
- R10: With `early_release` at 1, `tx_oe` falls at the edge that ends quarter 3 of bit 7. With `early_release` at 0, `tx_oe` changes only at edges that end a quarter-0 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, one cycle, marks quarter 0 of slot 0 |
| smp_sel | input | 2 | Receive sampling point select |
| early_release | input | 1 | 1: release output enable one quarter before slot end |
| rx_line | input | NUM_LINES | Serial receive lines |
| rx_valid | output | 1 | Byte-complete pulse |
| rx_slot | output | 7 | Slot number of the presented bytes |
| rx_bytes | output | NUM_LINES*8 | Received bytes, line i at bits 8i+7:8i |
| tx_bytes | input | NUM_LINES*8 | Bytes to send in the current slot |
| tx_en | input | NUM_LINES | Per-line drive enable for the current slot |
| tx_dout | output | NUM_LINES | Serial transmit data |
| tx_oe | output | NUM_LINES | Per-line output enable |

## Verification
The receive results are due one cycle after the sampling cycle of bit 7. The transmit data and enable are due one cycle after a quarter-0 cycle. The early release of the enable is due one cycle after the quarter-3 cycle of bit 7. The bench drives inputs on the falling edge and keeps its own frame position for the cycle it last drove. On the next falling edge it compares every output against the values that position implies. This holds the comparison to exactly one register stage, and the same rule covers frame syncs that are suppressed or that arrive early.

// File: rtl/tdm_pkg.sv
// Shared types for the TDM stream sampler.
// Assumes a four-quarter bit cell; the sampling point is encoded as below.
package tdm_pkg;

    typedef enum logic [1:0] {
        SMP_HALF     = 2'd0,
        SMP_3QTR     = 2'd1,
        SMP_FULL     = 2'd2,
        SMP_FULL_ALT = 2'd3
    } smp_point_e;

    // Map a sampling point select to the quarter index in which to sample.
    function automatic logic [1:0] smp_quarter(input logic [1:0] sel);
        case (smp_point_e'(sel))
            SMP_HALF: smp_quarter = 2'd1;
            SMP_3QTR: smp_quarter = 2'd2;
            default:  smp_quarter = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/tdm_timing.sv
// Frame position tracker: quarter, bit and slot of the current cycle.
// Assumes fsync is a single-cycle pulse in the clk domain; when it is high
// the current cycle is forced to position zero, otherwise the stored count.
module tdm_timing #(
    parameter int SLOTS = 128,
    parameter int BITS  = 8,
    localparam int QW   = 2,
    localparam int BW   = $clog2(BITS),
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic [QW-1:0] quarter,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] slot
);
    localparam logic [QW-1:0] LAST_Q    = '1;
    localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [QW-1:0] q_cnt;
    logic [BW-1:0] b_cnt;
    logic [SW-1:0] s_cnt;

    // Effective position: frame sync overrides the running count.
    always_comb begin
        quarter = fsync ? '0 : q_cnt;
        bit_idx = fsync ? '0 : b_cnt;
        slot    = fsync ? '0 : s_cnt;
    end

    // Advance the position by one quarter, wrapping bits and slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cnt <= '0;
            b_cnt <= '0;
            s_cnt <= '0;
        end else begin
            q_cnt <= quarter + 1'b1;
            if (quarter == LAST_Q) begin
                if (bit_idx == LAST_BIT) begin
                    b_cnt <= '0;
                    s_cnt <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
                end else begin
                    b_cnt <= bit_idx + 1'b1;
                    s_cnt <= slot;
                end
            end else begin
                b_cnt <= bit_idx;
                s_cnt <= slot;
            end
        end
    end

    // R2: the cycle after a frame sync is quarter 1 of bit 0 of slot 0.
    a_r2_sync_origin: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (fsync || (quarter == 2'd1 && bit_idx == '0 && slot == '0)));

    // R6: the last quarter of the last slot is followed by position zero.
    a_r6_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (quarter == LAST_Q && bit_idx == LAST_BIT && slot == LAST_SLOT)
        |=> (quarter == '0 && bit_idx == '0 && slot == '0));

endmodule

// File: rtl/tdm_rx_lane.sv
// Receive lane: shifts one sample per bit cell, MSB first, and latches the
// completed byte on the last bit. Assumes BITS >= 3.
module tdm_rx_lane #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_en,
    input  logic            last_bit,
    input  logic            din,
    output logic [BITS-1:0] byte_q
);
    logic [BITS-2:0] sr;

    // Shift in the sample and hand over the full byte on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            byte_q <= '0;
        end else if (sample_en) begin
            sr <= {sr[BITS-3:0], din};
            if (last_bit) begin
                byte_q <= {sr, din};
            end
        end
    end

    // R4: a completed byte ends with the sample just taken.
    a_r4_lsb_last: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && last_bit) |=> (byte_q[0] == $past(din)));

endmodule

// File: rtl/tdm_tx_lane.sv
// Transmit lane: captures a byte and an enable at slot start, presents one
// bit per bit cell MSB first, and releases the enable early when told.
// Assumes load, shift and drop are mutually exclusive and BITS >= 3.
module tdm_tx_lane #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic            drop,
    input  logic [BITS-1:0] byte_in,
    input  logic            en_in,
    output logic            dout,
    output logic            oe
);
    logic [BITS-2:0] sh;
    logic            en_hold;

    // Load, shift or release the lane's data and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            en_hold <= 1'b0;
            dout    <= 1'b0;
            oe      <= 1'b0;
        end else if (load) begin
            dout    <= byte_in[BITS-1];
            sh      <= byte_in[BITS-2:0];
            oe      <= en_in;
            en_hold <= en_in;
        end else if (shift) begin
            dout <= sh[BITS-2];
            sh   <= {sh[BITS-3:0], 1'b0};
            oe   <= en_hold;
        end else if (drop) begin
            oe <= 1'b0;
        end
    end

    // R9: a slot captured with the enable low leaves the line undriven.
    a_r9_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !en_in) |=> !oe);

endmodule

// File: rtl/tdm_phase_sampler.sv
// TDM stream sampler top: frame position, per-line receive and transmit
// lanes. Assumes clk runs at four times the bit rate and fsync is a
// one-cycle pulse at quarter 0 of slot 0.
module tdm_phase_sampler #(
    parameter int NUM_LINES = 32,
    parameter int SLOTS     = 128,
    parameter int BITS      = 8,
    localparam int SW       = $clog2(SLOTS),
    localparam int BW       = $clog2(BITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fsync,
    input  logic [1:0]                smp_sel,
    input  logic                      early_release,
    input  logic [NUM_LINES-1:0]      rx_line,
    output logic                      rx_valid,
    output logic [SW-1:0]             rx_slot,
    output logic [NUM_LINES*BITS-1:0] rx_bytes,
    input  logic [NUM_LINES*BITS-1:0] tx_bytes,
    input  logic [NUM_LINES-1:0]      tx_en,
    output logic [NUM_LINES-1:0]      tx_dout,
    output logic [NUM_LINES-1:0]      tx_oe
);
    import tdm_pkg::*;

    localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

    logic [1:0]    quarter;
    logic [BW-1:0] bit_idx;
    logic [SW-1:0] slot;
    logic          sample_en;
    logic          last_bit;
    logic          tx_load;
    logic          tx_shift;
    logic          tx_drop;

    tdm_timing #(.SLOTS(SLOTS), .BITS(BITS)) timing_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .quarter (quarter),
        .bit_idx (bit_idx),
        .slot    (slot)
    );

    // Decode lane strobes from the frame position and configuration.
    always_comb begin
        last_bit  = (bit_idx == LAST_BIT);
        sample_en = (quarter == smp_quarter(smp_sel));
        tx_load   = (quarter == 2'd0) && (bit_idx == '0);
        tx_shift  = (quarter == 2'd0) && (bit_idx != '0);
        tx_drop   = early_release && (quarter == 2'd3) && last_bit;
    end

    // Raise the byte-valid pulse with the slot number of the finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_slot  <= '0;
        end else begin
            rx_valid <= sample_en && last_bit;
            if (sample_en && last_bit) begin
                rx_slot <= slot;
            end
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        tdm_rx_lane #(.BITS(BITS)) rx_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .last_bit  (last_bit),
            .din       (rx_line[g]),
            .byte_q    (rx_bytes[g*BITS +: BITS])
        );
        tdm_tx_lane #(.BITS(BITS)) tx_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (tx_load),
            .shift   (tx_shift),
            .drop    (tx_drop),
            .byte_in (tx_bytes[g*BITS +: BITS]),
            .en_in   (tx_en[g]),
            .dout    (tx_dout[g]),
            .oe      (tx_oe[g])
        );
    end

    // R5: the byte-valid pulse never lasts two cycles.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: in synchronous release mode the enables move only after quarter 0.
    a_r10_sync_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_release && quarter != 2'd0) |=> $stable(tx_oe));

    // R10: early release clears every enable after quarter 3 of the last bit.
    a_r10_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (early_release && quarter == 2'd3 && last_bit) |=> (tx_oe == '0));

endmodule

// File: tb/tdm_phase_sampler_tb.sv
// Bench for the TDM stream sampler: keeps its own frame position, drives on
// the falling edge and checks the outputs of the cycle it last drove.
module tdm_phase_sampler_tb_top;

    localparam int L  = 4;
    localparam int FR = 128 * 8 * 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fsync = 1'b0;
    logic [1:0]     smp_sel = 2'd0;
    logic           early_release = 1'b0;
    logic [L-1:0]   rx_line = '0;
    logic           rx_valid;
    logic [6:0]     rx_slot;
    logic [L*8-1:0] rx_bytes;
    logic [L*8-1:0] tx_bytes = '0;
    logic [L-1:0]   tx_en = '0;
    logic [L-1:0]   tx_dout;
    logic [L-1:0]   tx_oe;

    tdm_phase_sampler #(.NUM_LINES(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .smp_sel(smp_sel),
        .early_release(early_release), .rx_line(rx_line),
        .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_bytes(rx_bytes),
        .tx_bytes(tx_bytes), .tx_en(tx_en), .tx_dout(tx_dout), .tx_oe(tx_oe)
    );

    always #5 clk = ~clk;

    // Vector table: {early release, sampling select, quarter1, quarter2, quarter3 bytes}
    localparam logic [26:0] VEC [5] = '{
        {1'b0, 2'd0, 8'hA5, 8'h3C, 8'h0F},
        {1'b1, 2'd1, 8'h5A, 8'hC3, 8'hF0},
        {1'b0, 2'd2, 8'h81, 8'h7E, 8'h18},
        {1'b1, 2'd3, 8'h12, 8'h34, 8'h56},
        {1'b0, 2'd0, 8'h00, 8'hFF, 8'h81}
    };

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit run = 0;
    bit have_prv = 0;
    bit gen_sync = 1;
    bit force_mid = 0;
    bit pend = 0;
    logic [26:0] pend_vec = '0;
    int cur = 0;
    int frames = 0;
    logic [7:0] pa = 0, pb = 0, pc = 0, tx_seed = 8'h3B;
    string slot_tag = "R2";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] rxpat(input int q, input int s, input int i);
        logic [7:0] b;
        case (q)
            1: b = pa;
            2: b = pb;
            3: b = pc;
            default: b = ~pa;
        endcase
        return b ^ 8'(s) ^ 8'(i * 37);
    endfunction

    function automatic logic [7:0] txbyte(input int s, input int i);
        return tx_seed ^ 8'(s * 3) ^ 8'(i << 6);
    endfunction

    function automatic bit txen(input int s, input int i);
        return ((s + i) % 3) != 0;
    endfunction

    // Check the cycle just processed, then drive the next one.
    always @(negedge clk) begin
        if (run) begin
            if (have_prv) begin
                int q, b, s, tgt;
                bit ev, eoe;
                q = cur % 4;
                b = (cur / 4) % 8;
                s = cur / 32;
                tgt = (smp_sel == 2'd0) ? 1 : (smp_sel == 2'd1) ? 2 : 3;
                ev = (b == 7) && (q == tgt);
                if (ev || rx_valid) begin
                    chk(rx_valid == ev, "R5", int'(rx_valid), int'(ev));
                    chk(int'(rx_slot) == s, slot_tag, int'(rx_slot), s);
                    for (int i = 0; i < L; i++) begin
                        // R3/R4: sampling quarter and MSB-first lane placement
                        chk(rx_bytes[i*8 +: 8] == rxpat(tgt, s, i), "R3/R4",
                            int'(rx_bytes[i*8 +: 8]), int'(rxpat(tgt, s, i)));
                    end
                end
                for (int i = 0; i < L; i++) begin
                    logic [7:0] tb;
                    eoe = txen(s, i) && !(early_release && q == 3 && b == 7);
                    chk(tx_oe[i] == eoe, "R9/R10", int'(tx_oe[i]), int'(eoe));
                    if (eoe) begin
                        tb = txbyte(s, i);
                        chk(tx_dout[i] == tb[7-b], "R8", int'(tx_dout[i]), int'(tb[7-b]));
                    end
                end
            end
            begin
                int nc;
                bit sy;
                sy = 1'b0;
                if (!have_prv) begin
                    nc = 0;
                    sy = 1'b1;
                end else if (force_mid && cur == 999) begin
                    nc = 0;
                    sy = 1'b1;
                    force_mid = 0;
                end else begin
                    nc = (cur + 1) % FR;
                    sy = (nc == 0) && gen_sync;
                end
                if (nc == 0) begin
                    frames++;
                    if (pend) begin
                        {early_release, smp_sel, pa, pb, pc} = pend_vec;
                        tx_seed = tx_seed + 8'h29;
                        pend = 0;
                    end
                end
                cur = nc;
                have_prv = 1;
                fsync = sy;
                for (int i = 0; i < L; i++) begin
                    logic [7:0] rb;
                    rb = rxpat(cur % 4, cur / 32, i);
                    rx_line[i] = rb[7 - (cur / 4) % 8];
                    tx_bytes[i*8 +: 8] = txbyte(cur / 32, i);
                    tx_en[i] = txen(cur / 32, i);
                end
            end
        end
    end

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(rx_valid == 1'b0, "R1", int'(rx_valid), 0);
        chk(tx_oe == '0, "R1", int'(tx_oe), 0);
        chk(tx_dout == '0, "R1", int'(tx_dout), 0);
        @(posedge clk);
        rst_n <= 1'b1;
        run = 1;
        for (int v = 0; v < 5; v++) begin
            pend_vec = VEC[v];
            pend = 1;
            wait_frames(1);
            wait_frames(1);
        end
        // R6: run a frame without frame sync, slot must wrap 127 -> 0
        slot_tag = "R6";
        gen_sync = 0;
        wait_frames(2);
        gen_sync = 1;
        wait_frames(1);
        // R7: frame sync arriving mid-frame restarts at slot 0
        slot_tag = "R7";
        pend_vec = VEC[1];
        pend = 1;
        wait_frames(1);
        force_mid = 1;
        while (force_mid) @(posedge clk);
        wait_frames(1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule